// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table held in memory. A request carries the linear address, a write flag and a user-mode flag. The block also takes the frame number of the page directory and a translation-enable bit. Both are sampled when the request is accepted. When translation is off, the address comes back unchanged and no memory access is made.

When translation is on, the walker reads the directory entry and then the table entry through a single 32-bit memory port with a request/acknowledge handshake. It checks presence and combined access rights at both levels. Before it reports completion, it writes the accessed and dirty flags back to memory. The result is either a physical address or a page fault. A fault carries a three-bit error code, and its linear address is kept for the fault handler.

A caller holds a request until `busy` is low. The result appears as a one-cycle `done` pulse.

Top module: `ptw_walker`

## Requirements
- R1: With translation disabled, an accepted request yields `done` one cycle later with `fault` low, `phys_addr` equal to the linear address, and no memory access.
- R2: The directory entry is read from {dir_base, lin[31:22], 2'b00}. The table entry is read from {directory entry bits 31:12, lin[21:12], 2'b00}. No other address is accessed.
- R3: A successful walk returns `phys_addr` = {table entry bits 31:12, lin[11:0]}.
- R4: An entry whose present bit (bit 0) is clear, at either level, ends the walk with a fault and error code bit 0 = 0. The table entry is not read if the directory entry is absent.
- R5: A user access (`req_user`=1) faults with error code bit 0 = 1 when the user-allowed bit (bit 2) is clear in either entry.
- R6: A user write faults when the writable bit (bit 1) is clear in either entry. A supervisor write ignores bit 1 and succeeds.
- R7: On a fault, error code bit 1 equals the write flag and bit 2 equals the user flag. `fault_addr` takes the faulting linear address and holds it until the next fault.
- R8: If the directory entry's accessed bit (bit 5) is clear on a successful walk, the entry is written back with only bit 5 added, before `done`. No write is made if bit 5 is already set. The dirty bit is never set in a directory entry.
- R9: On a successful walk, the table entry is written back once with bit 5 set, and with bit 6 (dirty) also set for write requests. No write is made when the needed bits are already set.
- R10: A walk that faults performs no memory write.
- R11: `mem_req` is low while idle. Once raised, it stays high with address, write flag and write data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request, accepted when `busy` is low |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| dir_base | input | 20 | Frame number of the page directory |
| xlat_en | input | 1 | Translation enable |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a page fault |
| fault_code | output | 3 | {user, write, protection} error code |
| phys_addr | output | 32 | Translated physical address |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
The accessed and dirty updates can both fall on one table-entry write. Write requests to entries with both flags clear provoke this. The bench then counts the writes and checks the final memory image: exactly one table write holding both bits, and a directory write holding only the accessed bit. A second pairing is a fault raised in the same step as the table read. Random entry flags cover both absent-entry and rights faults, and the bench confirms that no write ever follows a fault.

// File: rtl/ptw_pkg.sv
// Package: shared widths, entry bit positions and walk states.
// Assumes 4 KB pages, 4-byte entries and a two-level table.
package ptw_pkg;
    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned ENT_SH  = 2;
    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned LEVELS  = 2;

    localparam int unsigned BIT_P  = 0;
    localparam int unsigned BIT_RW = 1;
    localparam int unsigned BIT_US = 2;
    localparam int unsigned BIT_A  = 5;
    localparam int unsigned BIT_D  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WR_DIR,
        ST_WR_TBL
    } walk_st_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// Forms the byte addresses of the directory entry and the table entry.
// Assumes index fields and entry shift fill the address exactly.
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [FRAME_W-1:0] lin_page,
    output logic [VA_W-1:0]    dir_addr,
    output logic [VA_W-1:0]    tbl_addr
);
    localparam int unsigned TBL_LO = 0;
    localparam int unsigned DIR_LO = IDX_W;

    // Concatenate frame, index and entry shift for each level
    always_comb begin
        dir_addr = {root_frame, lin_page[DIR_LO +: IDX_W], {ENT_SH{1'b0}}};
        tbl_addr = {dir_frame,  lin_page[TBL_LO +: IDX_W], {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_perm_chk.sv
// Combines the rights of both levels and flags absence or denial.
// Assumes supervisor accesses are never denied on rights.
module ptw_perm_chk
    import ptw_pkg::*;
(
    input  logic [2:0] dir_flags,
    input  logic [2:0] tbl_flags,
    input  logic       acc_wr,
    input  logic       acc_usr,
    output logic       absent,
    output logic       deny
);
    logic usr_ok;
    logic wr_ok;

    // Most restrictive of the two levels decides
    always_comb begin
        absent = !dir_flags[BIT_P] || !tbl_flags[BIT_P];
        usr_ok = dir_flags[BIT_US] && tbl_flags[BIT_US];
        wr_ok  = dir_flags[BIT_RW] && tbl_flags[BIT_RW];
        deny   = acc_usr && (!usr_ok || (acc_wr && !wr_ok));
    end
endmodule

// File: rtl/ptw_ent_upd.sv
// Computes the written-back value of one entry and whether a write is needed.
// Assumes MARK_DIRTY is set only for the last level.
module ptw_ent_upd
    import ptw_pkg::*;
#(
    parameter bit MARK_DIRTY = 1'b0
)(
    input  logic [VA_W-1:0] ent_in,
    input  logic            acc_wr,
    output logic [VA_W-1:0] ent_out,
    output logic            need_wr
);
    // Set accessed always, dirty on writes at the last level only
    always_comb begin
        ent_out        = ent_in;
        ent_out[BIT_A] = 1'b1;
        if (MARK_DIRTY && acc_wr) begin
            ent_out[BIT_D] = 1'b1;
        end
        need_wr = (ent_out != ent_in);
    end
endmodule

// File: rtl/ptw_walker.sv
// Two-level page table walker with rights checks and flag write-back.
// Assumes memory returns read data in the acknowledge cycle and that
// callers hold req_valid until busy is low.
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] dir_base,
    input  logic               xlat_en,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    input  logic               mem_ack,
    input  logic [VA_W-1:0]    mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_code,
    output logic [VA_W-1:0]    phys_addr,
    output logic [VA_W-1:0]    fault_addr
);
    walk_st_t           st;
    logic [VA_W-1:0]    lin_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] root_q;
    logic [VA_W-1:0]    pde_q;
    logic [VA_W-1:0]    pte_q;
    logic               done_q;
    logic               fault_q;
    logic [2:0]         code_q;
    logic [VA_W-1:0]    phys_q;
    logic [VA_W-1:0]    faddr_q;

    logic [VA_W-1:0]    tbl_ent;
    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    tbl_addr;
    logic               absent;
    logic               deny;
    logic [VA_W-1:0]    upd_in   [LEVELS];
    logic [VA_W-1:0]    upd_out  [LEVELS];
    logic [LEVELS-1:0]  upd_need;

    // Table entry comes straight from memory in the read step
    always_comb begin
        tbl_ent   = (st == ST_RD_TBL) ? mem_rdata : pte_q;
        upd_in[0] = pde_q;
        upd_in[LEVELS-1] = tbl_ent;
    end

    ptw_addr_gen u_addr (
        .root_frame (root_q),
        .dir_frame  (pde_q[VA_W-1:OFF_W]),
        .lin_page   (lin_q[VA_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr)
    );

    ptw_perm_chk u_perm (
        .dir_flags (pde_q[2:0]),
        .tbl_flags (tbl_ent[2:0]),
        .acc_wr    (wr_q),
        .acc_usr   (usr_q),
        .absent    (absent),
        .deny      (deny)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_upd
        ptw_ent_upd #(
            .MARK_DIRTY (g == LEVELS - 1)
        ) u_upd (
            .ent_in  (upd_in[g]),
            .acc_wr  (wr_q),
            .ent_out (upd_out[g]),
            .need_wr (upd_need[g])
        );
    end

    // Drive the memory port from the current walk step
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WR_DIR) || (st == ST_WR_TBL);
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_RD_DIR: mem_addr = dir_addr;
            ST_WR_DIR: begin
                mem_addr  = dir_addr;
                mem_wdata = upd_out[0];
            end
            ST_RD_TBL: mem_addr = tbl_addr;
            ST_WR_TBL: begin
                mem_addr  = tbl_addr;
                mem_wdata = upd_out[LEVELS-1];
            end
            default: mem_addr = '0;
        endcase
    end

    // Walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            lin_q   <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            root_q  <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= '0;
            phys_q  <= '0;
            faddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q  <= req_lin;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        root_q <= dir_base;
                        if (xlat_en) begin
                            st <= ST_RD_DIR;
                        end else begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            phys_q  <= req_lin;
                        end
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ack) begin
                        pde_q <= mem_rdata;
                        if (!mem_rdata[BIT_P]) begin
                            st      <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            code_q  <= {usr_q, wr_q, 1'b0};
                            faddr_q <= lin_q;
                        end else begin
                            st <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ack) begin
                        pte_q <= mem_rdata;
                        if (absent || deny) begin
                            st      <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            code_q  <= {usr_q, wr_q, !absent};
                            faddr_q <= lin_q;
                        end else if (upd_need[0]) begin
                            st <= ST_WR_DIR;
                        end else if (upd_need[LEVELS-1]) begin
                            st <= ST_WR_TBL;
                        end else begin
                            st      <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            phys_q  <= {mem_rdata[VA_W-1:OFF_W], lin_q[OFF_W-1:0]};
                        end
                    end
                end
                ST_WR_DIR: begin
                    if (mem_ack) begin
                        if (upd_need[LEVELS-1]) begin
                            st <= ST_WR_TBL;
                        end else begin
                            st      <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            phys_q  <= {pte_q[VA_W-1:OFF_W], lin_q[OFF_W-1:0]};
                        end
                    end
                end
                ST_WR_TBL: begin
                    if (mem_ack) begin
                        st      <= ST_IDLE;
                        done_q  <= 1'b1;
                        fault_q <= 1'b0;
                        phys_q  <= {pte_q[VA_W-1:OFF_W], lin_q[OFF_W-1:0]};
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Expose registered results
    always_comb begin
        busy       = (st != ST_IDLE);
        done       = done_q;
        fault      = fault_q;
        fault_code = code_q;
        phys_addr  = phys_q;
        fault_addr = faddr_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Checker for the walker: handshake stability, result fields and
// fault side effects. Tracks the accepted request on its own.
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_lin,
    input logic            req_write,
    input logic            req_user,
    input logic            xlat_en,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [VA_W-1:0] mem_addr,
    input logic [VA_W-1:0] mem_wdata,
    input logic            done,
    input logic            fault,
    input logic [2:1]      code_hi,
    input logic [VA_W-1:0] phys_addr,
    input logic [VA_W-1:0] fault_addr
);
    logic [VA_W-1:0] lat_lin;
    logic            lat_wr;
    logic            lat_usr;
    logic            wrote;

    // Remember the accepted request and any write made during its walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_lin <= '0;
            lat_wr  <= 1'b0;
            lat_usr <= 1'b0;
            wrote   <= 1'b0;
        end else if (req_valid && !busy) begin
            lat_lin <= req_lin;
            lat_wr  <= req_write;
            lat_usr <= req_user;
            wrote   <= 1'b0;
        end else if (mem_req && mem_we && mem_ack) begin
            wrote <= 1'b1;
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && !xlat_en |=> done && !fault && phys_addr == $past(req_lin)); // R1
    AST_WRITE_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_A] && mem_wdata[BIT_P]); // R8
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> fault_addr == lat_lin); // R7
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> code_hi == {lat_usr, lat_wr}); // R7
    AST_PHYS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> phys_addr[OFF_W-1:0] == lat_lin[OFF_W-1:0]); // R3
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> !wrote); // R10
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_lin    (req_lin),
    .req_write  (req_write),
    .req_user   (req_user),
    .xlat_en    (xlat_en),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done       (done),
    .fault      (fault),
    .code_hi    (fault_code[2:1]),
    .phys_addr  (phys_addr),
    .fault_addr (fault_addr)
);

// File: tb/ptw_walker_bench.sv
// Bench: sparse memory model with random acknowledge latency, directed
// corner walks and seeded random walks checked against bench-side models.
module ptw_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WALK_LIMIT = 200;
    localparam int N_RAND     = 300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_lin;
    logic        req_write;
    logic        req_user;
    logic [19:0] dir_base;
    logic        xlat_en;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        done;
    logic        fault;
    logic [2:0]  fault_code;
    logic [31:0] phys_addr;
    logic [31:0] fault_addr;

    logic [31:0] mem [logic [31:0]];
    int n_chk = 0;
    int n_err = 0;
    int n_wr, n_rd, n_stray, n_unstable;
    logic [31:0] exp_dir_addr, exp_tbl_addr;
    logic        prev_pend;
    logic [31:0] prev_addr;
    logic        prev_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_lin    (req_lin),
        .req_write  (req_write),
        .req_user   (req_user),
        .dir_base   (dir_base),
        .xlat_en    (xlat_en),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .fault      (fault),
        .fault_code (fault_code),
        .phys_addr  (phys_addr),
        .fault_addr (fault_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Memory responder: random latency, stability tracking
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        prev_pend = 1'b0;
        prev_addr = '0;
        prev_we = 1'b0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            mem_rdata = '0;
            if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
                n_unstable++;
            prev_pend = 1'b0;
            if (rst_n && mem_req) begin
                if ($urandom_range(2) != 0) begin
                    mem_ack = 1'b1;
                    if (mem_addr != exp_dir_addr && mem_addr != exp_tbl_addr) n_stray++;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        n_wr++;
                    end else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                        n_rd++;
                    end
                end else begin
                    prev_pend = 1'b1;
                    prev_addr = mem_addr;
                    prev_we = mem_we;
                end
            end
        end
    end

    // One walk: set up tables, compute expectations, drive and check
    task automatic run_walk(input logic [31:0] lin, input bit wr, input bit usr, input bit en,
                            input logic [11:0] dbits, input logic [11:0] tbits,
                            input logic [19:0] root, input logic [19:0] dframe,
                            input logic [19:0] pframe, input string tag);
        logic [31:0] pde, pte, exp_pde, exp_pte, exp_phys;
        bit e_fault, e_prot;
        int e_wr, t;
        pde = {dframe, dbits};
        pte = {pframe, tbits};
        mem.delete();
        exp_dir_addr = {root, lin[31:22], 2'b00};
        exp_tbl_addr = {dframe, lin[21:12], 2'b00};
        mem[exp_dir_addr] = pde;
        mem[exp_tbl_addr] = pte;
        exp_pde = pde;
        exp_pte = pte;
        e_wr = 0;
        e_fault = 1'b0;
        e_prot = 1'b0;
        if (en) begin
            if (!pde[0] || !pte[0]) e_fault = 1'b1;
            else if (usr && (!(pde[2] && pte[2]) || (wr && !(pde[1] && pte[1])))) begin
                e_fault = 1'b1;
                e_prot = 1'b1;
            end
            if (!e_fault) begin
                exp_pde[5] = 1'b1;
                exp_pte[5] = 1'b1;
                if (wr) exp_pte[6] = 1'b1;
                e_wr = (exp_pde != pde ? 1 : 0) + (exp_pte != pte ? 1 : 0);
            end
            exp_phys = {pframe, lin[11:0]};
        end else begin
            exp_phys = lin;
        end
        n_wr = 0; n_rd = 0; n_stray = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        dir_base = root; xlat_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base = ~root;
        t = 0;
        while (!done && t < WALK_LIMIT) begin
            @(negedge clk);
            t++;
        end
        chk(done, {tag, " done seen"}, 32'(done), 32'd1);
        chk(fault == e_fault, {tag, " fault flag"}, 32'(fault), 32'(e_fault));
        if (e_fault) begin
            chk(fault_code == {usr, wr, e_prot}, {tag, " R7 error code"}, 32'(fault_code), 32'({usr, wr, e_prot}));
            chk(fault_addr == lin, {tag, " R7 fault address"}, fault_addr, lin);
            chk(n_rd == (pde[0] ? 2 : 1), {tag, " R4 read count"}, n_rd, pde[0] ? 2 : 1);
        end else begin
            chk(phys_addr == exp_phys, {tag, " R3 physical address"}, phys_addr, exp_phys);
        end
        chk(n_wr == e_wr, {tag, " R8/R9/R10 write count"}, n_wr, e_wr);
        chk(mem[exp_dir_addr] == exp_pde, {tag, " R8 directory image"}, mem[exp_dir_addr], exp_pde);
        chk(mem[exp_tbl_addr] == exp_pte, {tag, " R9 table image"}, mem[exp_tbl_addr], exp_pte);
        chk(n_stray == 0, {tag, " R2 addresses"}, n_stray, 0);
        if (!en) chk(n_rd == 0, {tag, " R1 no memory access"}, n_rd, 0);
    endtask

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    // Main sequence
    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        n_unstable = 0;
        exp_dir_addr = '1;
        exp_tbl_addr = '1;
        rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_write = 1'b0;
        req_user = 1'b0; dir_base = '0; xlat_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_req, "R11 reset state", {29'd0, done, busy, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_walk(32'hDEAD_BEEF, 1, 1, 0, 12'h000, 12'h000, 20'h00101, 20'h00201, 20'h12345, "R1 passthrough");
        run_walk(32'h1234_5678, 0, 0, 1, 12'h067, 12'h067, 20'h00102, 20'h00202, 20'hABCDE, "R2 R3 all set");
        run_walk(32'h8040_2123, 0, 1, 1, 12'h066, 12'h067, 20'h00103, 20'h00203, 20'h11111, "R4 dir absent");
        run_walk(32'h0040_3FFF, 1, 0, 1, 12'h067, 12'h066, 20'h00104, 20'h00204, 20'h22222, "R4 table absent");
        run_walk(32'h7FC0_1010, 0, 1, 1, 12'h063, 12'h067, 20'h00105, 20'h00205, 20'h33333, "R5 dir user");
        run_walk(32'h7FC0_1010, 0, 1, 1, 12'h067, 12'h063, 20'h00106, 20'h00206, 20'h33333, "R5 table user");
        run_walk(32'hFFFF_F000, 1, 1, 1, 12'h067, 12'h065, 20'h00107, 20'h00207, 20'h44444, "R6 user write ro");
        run_walk(32'hFFFF_F004, 1, 0, 1, 12'h065, 12'h065, 20'h00108, 20'h00208, 20'h55555, "R6 supervisor write ro");
        run_walk(32'h0000_0ABC, 1, 1, 1, 12'h007, 12'h007, 20'h00109, 20'h00209, 20'h66666, "R8 R9 both flags");
        run_walk(32'h0000_1ABC, 0, 1, 1, 12'h027, 12'h007, 20'h0010A, 20'h0020A, 20'h77777, "R9 read sets A only");
        run_walk(32'hCAFE_0001, 1, 1, 1, 12'h027, 12'h027, 20'h0010B, 20'h0020B, 20'h88888, "R9 write sets D");

        run_walk(32'h5555_A000, 1, 1, 1, 12'h067, 12'h060, 20'h0010C, 20'h0020C, 20'h99999, "R7 fault then");
        held = 32'h5555_A000;
        run_walk(32'h6666_B000, 0, 0, 1, 12'h067, 12'h067, 20'h0010D, 20'h0020D, 20'hAAAAA, "R7 success");
        chk(fault_addr == held, "R7 fault address held", fault_addr, held);

        for (int i = 0; i < N_RAND; i++) begin
            logic [11:0] db, tb;
            db = 12'($urandom);
            tb = 12'($urandom);
            if ($urandom_range(7) != 0) db[0] = 1'b1;
            if ($urandom_range(7) != 0) tb[0] = 1'b1;
            run_walk($urandom, 1'($urandom), 1'($urandom), ($urandom_range(9) != 0), db, tb,
                     20'h00100 + 20'($urandom_range(15)), 20'h00200 + 20'($urandom_range(15)),
                     20'($urandom), "random");
        end

        chk(n_unstable == 0, "R11 request held until acknowledge", n_unstable, 0);
        finish_run();
    end
endmodule